// File: doc/BRIEF.md
# Address-Monitor Wait Wake Controller

This controller sits beside a simple processor core and provides the hardware behind a monitor-arm and wait instruction pair. An arm strobe records a cache-line-sized, aligned address range and puts the monitor into its armed state. A later wait strobe puts the core into a low-power idle state, but only while the range is still armed. If the range is not armed, the wait completes at once. Every wait consumes the arm, so software re-arms before each wait.

While the core sleeps, the controller watches the snooped store bus and a set of event lines: interrupt, NMI, SMI, debug, machine check, init and core reset. The first qualifying event ends the sleep. The controller then emits a one-cycle wake pulse carrying a cause code and two hints: whether the core resumes at the next instruction, and whether it must take an interrupt. An interrupt only qualifies if interrupts were enabled at the moment the sleep began. The monitor remembers a store to the armed line that arrives before the wait, so a later wait falls through and that store is not lost.

The design has two state machines. The monitor FSM has states MON_IDLE, MON_ARMED and MON_TRIG, with these transitions:
- arm (from any state) leads to MON_ARMED and loads the line.
- A matching store in MON_ARMED leads to MON_TRIG.
- A wait in MON_ARMED leads to MON_TRIG (the arm is consumed).

The core FSM has states CORE_RUN and CORE_SLEEP, with these transitions:
- enter: a wait in CORE_RUN while the monitor is armed leads to CORE_SLEEP.
- fall-through: a wait in CORE_RUN while not armed stays in CORE_RUN and emits a wake pulse.
- wake: any qualified event in CORE_SLEEP leads back to CORE_RUN.

Top module: `mwk_ctrl`

## Requirements
- R1: After reset, sleep_o, wake_o, cause_o, resume_next_o and take_irq_o are 0 and the monitor is idle. A wait with the monitor idle or triggered leaves sleep_o at 0. One cycle after the wait, it gives a wake pulse with cause_o = 9 (fall-through), resume_next_o = 1 and take_irq_o = 0.
- R2: A wait while the monitor is armed, with no matching store in the same cycle, raises sleep_o on the next cycle and gives no wake pulse. The wait moves the monitor to triggered, so a second wait without a new arm falls through (R1).
- R3: A store whose address matches the armed line and arrives after the arm but before the wait, or in the same cycle as the wait, triggers the monitor. That wait then falls through (R1) instead of sleeping.
- R4: While sleeping, a valid snooped store whose address matches the armed line ends the sleep. Only the address bits above log2(LINE_BYTES) are compared. The wake pulse has cause_o = 1, resume_next_o = 1 and take_irq_o = 0. A store to any other line has no effect.
- R5: While sleeping, irq_i ends the sleep only if irq_en_i was 1 in the cycle the wait was accepted. Such a wake has cause_o = 2, take_irq_o = 1 and resume_next_o = 0. Changing irq_en_i during the sleep has no effect.
- R6: While sleeping, nmi_i wakes with cause_o = 4, take_irq_o = 1 and resume_next_o = 0. smi_i wakes with cause_o = 5, resume_next_o = 1 and take_irq_o = 0.
- R7: While sleeping, the following inputs each wake with resume_next_o = 0 and take_irq_o = 0: dbg_i (cause_o = 3), mce_i (cause_o = 6), init_i (cause_o = 7) and core_rst_i (cause_o = 8).
- R8: When several events arrive in the same cycle, cause_o reports the highest of them. The order from highest to lowest is core reset, init, machine check, SMI, NMI, debug, interrupt, store.
- R9: wake_o is a one-cycle pulse. sleep_o falls on the same edge that raises a wake. cause_o, resume_next_o and take_irq_o are 0 whenever wake_o is 0.
- R10: An arm from any state loads a new line and arms the monitor. A later sleep then wakes on a store to the new line and not on a store to the old one.
- R11: Arm and wait strobes during sleep are ignored, and the monitor stays triggered. Event lines and snooped stores while running give no wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| arm_i | input | 1 | Monitor arm strobe |
| arm_addr_i | input | AW | Address whose line is armed |
| wait_i | input | 1 | Wait command strobe |
| irq_en_i | input | 1 | Core interrupts-enabled flag |
| snoop_vld_i | input | 1 | Snooped store valid |
| snoop_addr_i | input | AW | Snooped store address |
| irq_i | input | 1 | Maskable interrupt request |
| nmi_i | input | 1 | Non-maskable interrupt |
| smi_i | input | 1 | System-management interrupt |
| dbg_i | input | 1 | Debug exception |
| mce_i | input | 1 | Machine check |
| init_i | input | 1 | Init request |
| core_rst_i | input | 1 | Core reset request (wake source) |
| sleep_o | output | 1 | Core is in the low-power state |
| wake_o | output | 1 | One-cycle wake / completion pulse |
| cause_o | output | 4 | Resume cause code, valid with wake_o |
| resume_next_o | output | 1 | Resume at the next instruction |
| take_irq_o | output | 1 | Take the pending interrupt |

## Verification
The assertions assume that the core never raises arm_i and wait_i in the same cycle. They also assume the core holds both strobes for one cycle per command. The stimulus drives each command as a single-cycle strobe on its own negative edge and never overlaps the two. Wake events are always separated by idle cycles. Each wake is predicted as a scoreboard entry before its triggering edge, and any pulse that has no matching entry counts as a failure.

// File: rtl/mwk_pkg.sv
package mwk_pkg;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_ARMED = 2'd1,
        MON_TRIG  = 2'd2
    } mon_state_e;

    typedef enum logic {
        CORE_RUN   = 1'b0,
        CORE_SLEEP = 1'b1
    } core_state_e;

    typedef enum logic [3:0] {
        CZ_NONE  = 4'd0,
        CZ_STORE = 4'd1,
        CZ_IRQ   = 4'd2,
        CZ_DBG   = 4'd3,
        CZ_NMI   = 4'd4,
        CZ_SMI   = 4'd5,
        CZ_MCE   = 4'd6,
        CZ_INIT  = 4'd7,
        CZ_RST   = 4'd8,
        CZ_FALL  = 4'd9
    } wake_cause_e;

    // Event vector index: a higher index means a higher priority
    localparam int NUM_EVT = 8;

    function automatic wake_cause_e idx_to_cause(input int idx);
        unique case (idx)
            0:       return CZ_STORE;
            1:       return CZ_IRQ;
            2:       return CZ_DBG;
            3:       return CZ_NMI;
            4:       return CZ_SMI;
            5:       return CZ_MCE;
            6:       return CZ_INIT;
            7:       return CZ_RST;
            default: return CZ_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mwk_wake_arb.sv
module mwk_wake_arb
    import mwk_pkg::*;
#(
    parameter int N = NUM_EVT
) (
    input  logic [N-1:0] evt_i,
    output logic         any_o,
    output wake_cause_e  cause_o
);

    always_comb begin
        cause_o = CZ_NONE;
        for (int i = 0; i < N; i++) begin
            if (evt_i[i]) cause_o = idx_to_cause(i);
        end
        any_o = |evt_i;
        // R8: any raised event yields a real cause code
        a_r8_code_valid: assert (!any_o || cause_o != CZ_NONE);
    end

endmodule

// File: rtl/mwk_monitor.sv
module mwk_monitor
    import mwk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_i,
    input  logic          arm_i,
    input  logic [AW-1:0] arm_addr_i,
    input  logic          wait_i,
    input  logic          snoop_vld_i,
    input  logic [AW-1:0] snoop_addr_i,
    output logic          armed_o,
    output logic          arm_hit_o,
    output logic          line_hit_o
);

    localparam int          OFS  = $clog2(LINE_BYTES);
    localparam logic [AW-1:0] MASK = ~((AW'(1) << OFS) - AW'(1));

    mon_state_e    state_q, state_d;
    logic [AW-1:0] base_q;

    assign line_hit_o = snoop_vld_i && ((snoop_addr_i & MASK) == base_q);
    assign armed_o    = (state_q == MON_ARMED);
    assign arm_hit_o  = line_hit_o && armed_o;

    always_comb begin
        state_d = state_q;
        if (!hold_i) begin
            unique case (state_q)
                MON_IDLE:  if (arm_i) state_d = MON_ARMED;
                MON_ARMED: begin
                    if (arm_i)                      state_d = MON_ARMED;
                    else if (wait_i || arm_hit_o)   state_d = MON_TRIG;
                end
                MON_TRIG:  if (arm_i) state_d = MON_ARMED;
                default:   state_d = MON_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            if (!hold_i && arm_i) base_q <= arm_addr_i & MASK;
        end
    end

    a_r2_wait_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && wait_i && !arm_i && state_q == MON_ARMED) |=> (state_q == MON_TRIG));
    a_r10_arm_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && arm_i) |=> (state_q == MON_ARMED));
    a_r11_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && $past(hold_i)) |-> $stable(state_q));

endmodule

// File: rtl/mwk_ctrl.sv
module mwk_ctrl
    import mwk_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic [AW-1:0] arm_addr_i,
    input  logic          wait_i,
    input  logic          irq_en_i,
    input  logic          snoop_vld_i,
    input  logic [AW-1:0] snoop_addr_i,
    input  logic          irq_i,
    input  logic          nmi_i,
    input  logic          smi_i,
    input  logic          dbg_i,
    input  logic          mce_i,
    input  logic          init_i,
    input  logic          core_rst_i,
    output logic          sleep_o,
    output logic          wake_o,
    output logic [3:0]    cause_o,
    output logic          resume_next_o,
    output logic          take_irq_o
);

    core_state_e       state_q, state_d;
    logic              irq_en_q;
    logic              hold, armed, arm_hit, line_hit;
    logic              enter_now, fall_now, wake_now, evt_any;
    logic [NUM_EVT-1:0] evt;
    wake_cause_e       evt_cause, cause_d;

    assign hold = (state_q == CORE_SLEEP);

    mwk_monitor #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold_i       (hold),
        .arm_i        (arm_i),
        .arm_addr_i   (arm_addr_i),
        .wait_i       (wait_i),
        .snoop_vld_i  (snoop_vld_i),
        .snoop_addr_i (snoop_addr_i),
        .armed_o      (armed),
        .arm_hit_o    (arm_hit),
        .line_hit_o   (line_hit)
    );

    assign evt = {core_rst_i, init_i, mce_i, smi_i, nmi_i, dbg_i,
                  irq_i && irq_en_q, line_hit};

    mwk_wake_arb #(.N(NUM_EVT)) u_arb (
        .evt_i   (evt),
        .any_o   (evt_any),
        .cause_o (evt_cause)
    );

    assign enter_now = !hold && wait_i && armed && !arm_hit;
    assign fall_now  = !hold && wait_i && !(armed && !arm_hit);
    assign wake_now  = hold && evt_any;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_RUN:   if (enter_now) state_d = CORE_SLEEP;
            CORE_SLEEP: if (wake_now)  state_d = CORE_RUN;
            default:    state_d = CORE_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CORE_RUN;
            irq_en_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (enter_now) irq_en_q <= irq_en_i;
        end
    end

    always_comb begin
        if (fall_now)      cause_d = CZ_FALL;
        else if (wake_now) cause_d = evt_cause;
        else               cause_d = CZ_NONE;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_o        <= 1'b0;
            cause_o       <= CZ_NONE;
            resume_next_o <= 1'b0;
            take_irq_o    <= 1'b0;
        end else begin
            wake_o        <= fall_now || wake_now;
            cause_o       <= cause_d;
            resume_next_o <= (cause_d == CZ_FALL) || (cause_d == CZ_STORE)
                             || (cause_d == CZ_SMI);
            take_irq_o    <= (cause_d == CZ_IRQ) || (cause_d == CZ_NMI);
        end
    end

    assign sleep_o = hold;

    a_r1_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && wait_i && !armed) |=> (wake_o && cause_o == CZ_FALL && resume_next_o && !sleep_o));
    a_r2_enter_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && wait_i && armed && !line_hit) |=> (sleep_o && !wake_o));
    a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && !irq_en_q && !line_hit && !core_rst_i && !init_i && !mce_i
         && !smi_i && !nmi_i && !dbg_i) |=> sleep_o);
    a_r7_reset_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_o && core_rst_i) |=> (wake_o && cause_o == CZ_RST && !sleep_o));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);
    a_r9_sleep_drops: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> !sleep_o);
    a_r9_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_o |-> (cause_o == 4'd0 && !resume_next_o && !take_irq_o));
    a_r11_run_no_event_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep_o && !wait_i) |=> !wake_o);

endmodule

// File: tb/tb_mwk_ctrl.sv
module tb_mwk_ctrl;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          arm_i, wait_i, irq_en_i, snoop_vld_i;
    logic [AW-1:0] arm_addr_i, snoop_addr_i;
    logic          irq_i, nmi_i, smi_i, dbg_i, mce_i, init_i, core_rst_i;
    logic          sleep_o, wake_o, resume_next_o, take_irq_o;
    logic [3:0]    cause_o;

    always #4 clk = ~clk;

    mwk_ctrl #(.AW(AW), .LINE_BYTES(64)) dut (
        .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .arm_addr_i(arm_addr_i),
        .wait_i(wait_i), .irq_en_i(irq_en_i), .snoop_vld_i(snoop_vld_i),
        .snoop_addr_i(snoop_addr_i), .irq_i(irq_i), .nmi_i(nmi_i), .smi_i(smi_i),
        .dbg_i(dbg_i), .mce_i(mce_i), .init_i(init_i), .core_rst_i(core_rst_i),
        .sleep_o(sleep_o), .wake_o(wake_o), .cause_o(cause_o),
        .resume_next_o(resume_next_o), .take_irq_o(take_irq_o)
    );

    typedef struct {
        logic [3:0] cause;
        logic       resume;
        logic       take;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   live   = 0;
    bit   done   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic r, input logic t, input string tag);
        exp_t e;
        e.cause = c; e.resume = r; e.take = t; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Scoreboard monitor: samples 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (live) begin
                if (wake_o) begin
                    if (exp_q.size() == 0) begin
                        n_chk++; n_fail++;
                        $display("FAIL R11: actual unexpected wake cause %0d expected no wake", cause_o);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk({e.tag, " cause"},  32'(cause_o),       32'(e.cause));
                        chk({e.tag, " resume"}, 32'(resume_next_o), 32'(e.resume));
                        chk({e.tag, " take"},   32'(take_irq_o),    32'(e.take));
                        chk("R9 sleep low with wake", 32'(sleep_o), 32'd0);
                    end
                end else if (cause_o != 4'd0 || resume_next_o || take_irq_o) begin
                    n_chk++; n_fail++;
                    $display("FAIL R9: actual fields %0d/%0b/%0b expected 0 without wake",
                             cause_o, resume_next_o, take_irq_o);
                end
            end
        end
    end

    task automatic arm(input logic [AW-1:0] a);
        @(negedge clk); arm_i = 1'b1; arm_addr_i = a;
        @(negedge clk); arm_i = 1'b0;
    endtask

    task automatic do_wait(input logic ien);
        @(negedge clk); wait_i = 1'b1; irq_en_i = ien;
        @(negedge clk); wait_i = 1'b0;
    endtask

    task automatic store(input logic [AW-1:0] a);
        @(negedge clk); snoop_vld_i = 1'b1; snoop_addr_i = a;
        @(negedge clk); snoop_vld_i = 1'b0;
    endtask

    // bits: {core_rst, init, mce, smi, nmi, dbg, irq}
    task automatic events(input logic [6:0] m, input logic st, input logic [AW-1:0] a);
        @(negedge clk);
        {core_rst_i, init_i, mce_i, smi_i, nmi_i, dbg_i, irq_i} = m;
        snoop_vld_i = st; snoop_addr_i = a;
        @(negedge clk);
        {core_rst_i, init_i, mce_i, smi_i, nmi_i, dbg_i, irq_i} = '0;
        snoop_vld_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sleep_then(input logic [6:0] m, input logic st,
                              input logic [3:0] c, input logic r, input logic t, input string tag);
        arm(32'h0000_1000);
        do_wait(1'b1);
        chk({tag, " asleep"}, 32'(sleep_o), 32'd1);
        push(c, r, t, tag);
        events(m, st, 32'h0000_1010);
        chk({tag, " awake"}, 32'(sleep_o), 32'd0);
        idle(2);
    endtask

    localparam logic [AW-1:0] LA = 32'h0000_1000;
    localparam logic [AW-1:0] LB = 32'h0000_2040;

    initial begin
        rst_n = 1'b0; arm_i = 0; wait_i = 0; irq_en_i = 0; snoop_vld_i = 0;
        arm_addr_i = '0; snoop_addr_i = '0;
        {core_rst_i, init_i, mce_i, smi_i, nmi_i, dbg_i, irq_i} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset sleep", 32'(sleep_o), 32'd0);
        chk("R1 reset wake",  32'(wake_o),  32'd0);
        chk("R1 reset cause", 32'(cause_o), 32'd0);
        // R1: wait with idle monitor falls through
        push(4'd9, 1'b1, 1'b0, "R1 idle fall");
        do_wait(1'b1);
        chk("R1 no sleep", 32'(sleep_o), 32'd0);
        idle(2);

        // R2 enter, R4 other-line store ignored, matching store wakes
        arm(LA);
        do_wait(1'b1);
        chk("R2 asleep", 32'(sleep_o), 32'd1);
        store(LB);
        idle(2);
        chk("R4 other line stays asleep", 32'(sleep_o), 32'd1);
        push(4'd1, 1'b1, 1'b0, "R4 store wake");
        store(LA + 32'h3F);
        chk("R4 awake", 32'(sleep_o), 32'd0);
        idle(2);
        // R2: arm consumed, second wait falls through
        push(4'd9, 1'b1, 1'b0, "R2 consumed fall");
        do_wait(1'b1);
        chk("R2 no re-sleep", 32'(sleep_o), 32'd0);
        idle(2);

        // R3: store before wait triggers monitor
        arm(LA);
        store(LA + 32'h8);
        push(4'd9, 1'b1, 1'b0, "R3 early store fall");
        do_wait(1'b1);
        chk("R3 no sleep", 32'(sleep_o), 32'd0);
        idle(2);
        // R3: store in same cycle as wait
        arm(LA);
        push(4'd9, 1'b1, 1'b0, "R3 same-cycle fall");
        @(negedge clk); wait_i = 1'b1; snoop_vld_i = 1'b1; snoop_addr_i = LA;
        @(negedge clk); wait_i = 1'b0; snoop_vld_i = 1'b0;
        chk("R3 same-cycle no sleep", 32'(sleep_o), 32'd0);
        idle(2);

        // R5: masked interrupt ignored even if enable changes during sleep
        arm(LA);
        do_wait(1'b0);
        events(7'b0000001, 1'b0, '0);
        irq_en_i = 1'b1;
        events(7'b0000001, 1'b0, '0);
        idle(1);
        chk("R5 masked irq stays asleep", 32'(sleep_o), 32'd1);
        // R6: NMI wakes and takes interrupt
        push(4'd4, 1'b0, 1'b1, "R6 nmi");
        events(7'b0000100, 1'b0, '0);
        chk("R6 nmi awake", 32'(sleep_o), 32'd0);
        idle(2);
        // R5: enabled interrupt
        sleep_then(7'b0000001, 1'b0, 4'd2, 1'b0, 1'b1, "R5 irq");
        // R6: SMI
        sleep_then(7'b0001000, 1'b0, 4'd5, 1'b1, 1'b0, "R6 smi");
        // R7: debug, mce, init, core reset
        sleep_then(7'b0000010, 1'b0, 4'd3, 1'b0, 1'b0, "R7 dbg");
        sleep_then(7'b0010000, 1'b0, 4'd6, 1'b0, 1'b0, "R7 mce");
        sleep_then(7'b0100000, 1'b0, 4'd7, 1'b0, 1'b0, "R7 init");
        sleep_then(7'b1000000, 1'b0, 4'd8, 1'b0, 1'b0, "R7 reset");
        // R8: priority
        sleep_then(7'b1111111, 1'b1, 4'd8, 1'b0, 1'b0, "R8 all");
        sleep_then(7'b0111001, 1'b0, 4'd7, 1'b0, 1'b0, "R8 init over mce/smi/irq");
        sleep_then(7'b0011111, 1'b1, 4'd6, 1'b0, 1'b0, "R8 mce over smi");
        sleep_then(7'b0001111, 1'b1, 4'd5, 1'b1, 1'b0, "R8 smi over nmi");
        sleep_then(7'b0000111, 1'b1, 4'd4, 1'b0, 1'b1, "R8 nmi over dbg");
        sleep_then(7'b0000011, 1'b1, 4'd3, 1'b0, 1'b0, "R8 dbg over irq");
        sleep_then(7'b0000001, 1'b1, 4'd2, 1'b0, 1'b1, "R8 irq over store");

        // R10: re-arm to a new line
        arm(LA);
        arm(LB);
        do_wait(1'b1);
        store(LA);
        idle(1);
        chk("R10 old line ignored", 32'(sleep_o), 32'd1);
        push(4'd1, 1'b1, 1'b0, "R10 new line wake");
        store(LB + 32'h4);
        idle(2);

        // R11: events while running give no wake
        events(7'b1111111, 1'b1, LB);
        idle(2);
        // R11: arm and wait during sleep ignored
        arm(LA);
        do_wait(1'b1);
        arm(LA);
        do_wait(1'b1);
        chk("R11 still asleep", 32'(sleep_o), 32'd1);
        push(4'd5, 1'b1, 1'b0, "R11 smi wake");
        events(7'b0001000, 1'b0, '0);
        idle(2);
        push(4'd9, 1'b1, 1'b0, "R11 monitor still triggered");
        do_wait(1'b1);
        idle(3);
        chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule